// File: doc/BRIEF.md
# PWM Dead-Band Insertion Unit

This unit sits between a single pulse-width generator and a pair of output pins that drive the high-side and low-side switches of a half bridge. When dead-band insertion is switched on, the unit builds both outputs from the generator's A signal alone. The A output follows A, but each rising edge is held back by a programmable number of clock ticks. The B output is the inverse of A, and each of its rising edges is held back by a second programmable count that starts at A's falling edge. Each output turns off on the same tick that its driving level goes away. The two switches are therefore never on together, and a gap separates one turning off from the other turning on.

When insertion is switched off, the A and B generator signals pass to the pins independently and the delay settings have no effect. Both outputs are registered, so the unit adds one clock of latency in either mode. The two delay counts are 12 bits wide. A level that returns before its delay has run out produces no pulse at all.

Top module: `pwm_deadband`

## Requirements
- R1: While `rst` is high, and after the clock edge that samples it, `out_a` and `out_b` are 0.
- R2: With `dband_en` = 0, `out_a` and `out_b` equal the values of `in_a` and `in_b` at the previous clock edge.
- R3: With `dband_en` = 1, a rising `in_a` first sampled at edge k makes `out_a` go high after edge k + `rise_dly`, provided `in_a` stays high up to that edge.
- R4: With `dband_en` = 1, `out_a` goes low after the first edge that samples `in_a` low.
- R5: With `dband_en` = 1, `out_b` goes low after the first edge that samples `in_a` high. A falling `in_a` first sampled at edge k makes `out_b` go high after edge k + `fall_dly`, provided `in_a` stays low up to that edge.
- R6: With `dband_en` = 1, `in_b` has no effect on `out_b`.
- R7: Once `dband_en` has been sampled high, `out_a` and `out_b` are never 1 in the same cycle until it is sampled low again.
- R8: If the driving level goes away before its delay has elapsed, that output stays low. A later edge then waits the full delay again.
- R9: A delay of 0 makes the pair plain complements of the previous-edge value of `in_a`, with no gap.
- R10: The largest delay, 4095, is honoured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every delay is counted in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| dband_en | input | 1 | 1: derive both outputs from `in_a` with delays; 0: pass through |
| in_a | input | 1 | Generator A signal |
| in_b | input | 1 | Generator B signal, used only when insertion is off |
| rise_dly | input | 12 | Ticks from `in_a` rising to `out_a` rising |
| fall_dly | input | 12 | Ticks from `in_a` falling to `out_b` rising |
| out_a | output | 1 | Registered high-side output |
| out_b | output | 1 | Registered low-side output |

## Verification
Every result is due a fixed number of clock edges after the stimulus that causes it. In pass-through mode, and for every turn-off, the output changes after the first edge that samples the new input. A delayed rise follows the first sampling edge by exactly the programmed count. The bench drives its inputs on falling clock edges and reads the outputs on falling edges. For a delay d, it expects the output still low on the d-th falling edge after the stimulus and high on the (d+1)-th, so a count that is one short or one long fails. Non-overlap is checked on every falling edge while insertion is on.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int DBI_DLY_W = 12;
  localparam int DBI_NCH   = 2;
  typedef enum logic { CH_HIGH = 1'b0, CH_LOW = 1'b1 } dbi_ch_e;
endpackage

// File: rtl/dbi_edge_delay.sv
module dbi_edge_delay #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bypass,
  input  logic          bypass_lvl,
  input  logic          level,
  input  logic [DW-1:0] delay,
  output logic          q
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (bypass) begin
      cnt <= '0;
      q   <= bypass_lvl;
    end else if (!level) begin
      cnt <= '0;
      q   <= 1'b0;
    end else if (!q) begin
      if (cnt >= delay) q <= 1'b1;
      else              cnt <= cnt + 1'b1;
    end
  end

  // R4
  drop_now_chk: assert property (@(posedge clk) disable iff (rst)
    (!bypass && !level) |=> !q);

  // R8
  rise_held_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> ($past(bypass) || $past(level)));
endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
  import dbi_pkg::*;
#(
  parameter int DW = DBI_DLY_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dband_en,
  input  logic          in_a,
  input  logic          in_b,
  input  logic [DW-1:0] rise_dly,
  input  logic [DW-1:0] fall_dly,
  output logic          out_a,
  output logic          out_b
);
  localparam int NCH = DBI_NCH;

  logic          lvl     [NCH];
  logic          byp_lvl [NCH];
  logic [DW-1:0] dly     [NCH];
  logic          chq     [NCH];
  logic          en_q;

  assign lvl[CH_HIGH]     = in_a;
  assign lvl[CH_LOW]      = ~in_a;
  assign byp_lvl[CH_HIGH] = in_a;
  assign byp_lvl[CH_LOW]  = in_b;
  assign dly[CH_HIGH]     = rise_dly;
  assign dly[CH_LOW]      = fall_dly;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dbi_edge_delay #(.DW(DW)) i_dly (
      .clk        (clk),
      .rst        (rst),
      .bypass     (~dband_en),
      .bypass_lvl (byp_lvl[g]),
      .level      (lvl[g]),
      .delay      (dly[g]),
      .q          (chq[g])
    );
  end

  assign out_a = chq[CH_HIGH];
  assign out_b = chq[CH_LOW];

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= dband_en;
  end

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |-> !(out_a && out_b));

  // R2
  pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dband_en)) |-> (out_a == $past(in_a) && out_b == $past(in_b)));
endmodule

// File: tb/test_pwm_deadband.sv
module test_pwm_deadband;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dband_en = 1'b0;
  logic in_a = 1'b0;
  logic in_b = 1'b0;
  logic [11:0] rise_dly = '0;
  logic [11:0] fall_dly = '0;
  logic out_a, out_b;
  int total = 0;
  int bad = 0;
  bit watch_ovl = 1'b0;

  pwm_deadband i_pwm_deadband (
    .clk(clk), .rst(rst), .dband_en(dband_en), .in_a(in_a), .in_b(in_b),
    .rise_dly(rise_dly), .fall_dly(fall_dly), .out_a(out_a), .out_b(out_b)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (watch_ovl) chk("R7 overlap", out_a & out_b, 1'b0);
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1 out_a", out_a, 1'b0);
    chk("R1 out_b", out_b, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_pass();
    dband_en = 1'b0;
    rise_dly = 12'd7; fall_dly = 12'd7;
    for (int p = 0; p < 4; p++) begin
      in_a = p[0]; in_b = p[1];
      tick();
      chk("R2 out_a", out_a, p[0]);
      chk("R2 out_b", out_b, p[1]);
    end
  endtask

  task automatic t_delays();
    rise_dly = 12'd5; fall_dly = 12'd3;
    in_a = 1'b0; in_b = 1'b1; dband_en = 1'b1;
    tick(); watch_ovl = 1'b1;
    repeat (8) tick();
    chk("R5 out_b settled high", out_b, 1'b1);
    in_a = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      in_b = i[0];
      tick();
      chk("R3 out_a", out_a, (i == 6));
      chk("R5/R6 out_b low", out_b, 1'b0);
    end
    in_a = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      in_b = ~i[0];
      tick();
      chk("R4 out_a", out_a, 1'b0);
      chk("R5 out_b", out_b, (i == 4));
    end
  endtask

  task automatic t_cancel();
    rise_dly = 12'd6; fall_dly = 12'd2;
    in_a = 1'b0;
    repeat (4) tick();
    in_a = 1'b1;
    repeat (3) begin tick(); chk("R8 short pulse", out_a, 1'b0); end
    in_a = 1'b0;
    repeat (4) begin tick(); chk("R8 after cancel", out_a, 1'b0); end
    in_a = 1'b1;
    for (int i = 1; i <= 7; i++) begin
      tick();
      chk("R8 full restart", out_a, (i == 7));
    end
    in_a = 1'b0;
    tick();
    in_a = 1'b1;
    tick();
    chk("R8 out_b cancelled", out_b, 1'b0);
  endtask

  task automatic t_zero();
    logic [7:0] pat;
    rise_dly = '0; fall_dly = '0;
    pat = 8'b1011_0010;
    for (int i = 0; i < 8; i++) begin
      in_a = pat[i];
      tick();
      chk("R9 out_a", out_a, pat[i]);
      chk("R9 out_b", out_b, ~pat[i]);
    end
  endtask

  task automatic t_max();
    rise_dly = 12'd4095; fall_dly = 12'd0;
    in_a = 1'b0;
    repeat (3) tick();
    in_a = 1'b1;
    repeat (4095) tick();
    chk("R10 still low at 4095", out_a, 1'b0);
    tick();
    chk("R10 high at 4096", out_a, 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_pass();
        t_delays();
        t_cancel();
        t_zero();
        t_max();
      end
      begin
        repeat (20000) @(negedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule